// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block prepares the second operand of a 32-bit datapath. Given a register operand, a shift kind, a 5-bit amount and the current carry flag, it returns the shifted operand and the carry-out produced by the shift. The carry-out feeds the carry flag when a logical operation updates the flags.

A second path builds constant operands. An 8-bit value is zero-extended and rotated right by twice a 4-bit rotate field. A select input chooses which of the two paths drives the outputs.

The block is purely combinational and has no state. A single left-to-right rotator is shared by every register shift kind. Left shifts reverse the bit order before the rotator and again after it. Logical and arithmetic right shifts mask or fill the rotated word, and the carry-out is always the top bit of the rotated word.

Top module: `bshift_top`

## Requirements
- R1: With `imm_sel_i`=0, `amt_i`=0 and a kind code of 0 to 4, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`.
- R2: Kind codes 0 and 1 are both a left shift that fills with zeros. For `amt_i`=n>0, `result_o` = `opnd_i` << n and `carry_o` = `opnd_i`[32-n].
- R3: Kind code 2 is a logical right shift. For n>0, `result_o` = `opnd_i` >> n with zero fill, and `carry_o` = `opnd_i`[n-1].
- R4: Kind code 3 is an arithmetic right shift. For n>0, the vacated top n bits are copies of `opnd_i`[31], and `carry_o` = `opnd_i`[n-1].
- R5: Kind code 4 rotates right by n. For n>0, `carry_o` equals `result_o`[31], which is `opnd_i`[n-1].
- R6: Kind code 5 rotates right by one bit through the carry, whatever `amt_i` is. `result_o` = {`carry_i`, `opnd_i`[31:1]} and `carry_o` = `opnd_i`[0].
- R7: Kind codes 6 and 7 are reserved. They pass `opnd_i` through unchanged, with `carry_o` = `carry_i`, for any amount.
- R8: With `imm_sel_i`=1, `result_o` is `imm_val_i` zero-extended to 32 bits and rotated right by 2×`imm_rot_i`. `opnd_i`, `kind_i` and `amt_i` have no effect.
- R9: With `imm_sel_i`=1, `carry_o` equals `carry_i` when `imm_rot_i`=0, and equals `result_o`[31] otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Register operand to shift |
| kind_i | input | 3 | Shift kind code (0/1 left, 2 logical right, 3 arithmetic right, 4 rotate, 5 rotate through carry, 6/7 reserved) |
| amt_i | input | 5 | Shift amount, 0 to 31 |
| carry_i | input | 1 | Current carry flag |
| imm_sel_i | input | 1 | 1 selects the constant path, 0 the register path |
| imm_val_i | input | 8 | Constant byte |
| imm_rot_i | input | 4 | Rotate field; the rotation is twice this value |
| result_o | output | 32 | Shifted or expanded operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Immediate assertions placed beside the logic check several properties of every settled input. The zero-amount pass-through is checked. So are the fixed bit moves of the rotate-through-carry kind and the sign copy in the top bit of an arithmetic shift. The assertions also check that rotation preserves the population count and that the constant path's carry rule holds. Exact values at every amount cannot be shown by these properties. This covers the carry taken from bit 32-n or n-1, zero fill against sign fill, the equality of the two left codes, and the independence of each path from the other path's inputs. The bench's sweep of every kind across all 32 amounts, and of all 4096 constant encodings, against its own reference model shows these.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        SK_SHL   = 3'd0,
        SK_SHL_A = 3'd1,
        SK_SHR   = 3'd2,
        SK_SAR   = 3'd3,
        SK_ROT   = 3'd4,
        SK_RCX   = 3'd5,
        SK_RSV6  = 3'd6,
        SK_RSV7  = 3'd7
    } shift_kind_e;

endpackage

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [W-1:0]     res_o,
    output logic             carry_o
);

    localparam int LOG = AMT_W;

    shift_kind_e           kind;
    logic                  go_left;
    logic [W-1:0]          opnd_rev;
    logic [W-1:0]          rot_src;
    logic [LOG:0][W-1:0]   stage;
    logic [W-1:0]          rot;
    logic [W-1:0]          keep_mask;
    logic [W-1:0]          masked;
    logic [W-1:0]          masked_rev;
    logic                  nonzero;

    assign kind    = shift_kind_e'(kind_i);
    assign go_left = (kind == SK_SHL) || (kind == SK_SHL_A);
    assign nonzero = (amt_i != '0);

    // bit reversal used before and after the rotator for left shifts
    for (genvar g = 0; g < W; g++) begin : g_rev
        assign opnd_rev[g]   = opnd_i[W-1-g];
        assign masked_rev[g] = masked[W-1-g];
    end

    assign rot_src  = go_left ? opnd_rev : opnd_i;
    assign stage[0] = rot_src;

    // logarithmic right rotator, one stage per amount bit
    for (genvar k = 0; k < LOG; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k]
            ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
            : stage[k];
    end

    assign rot       = stage[LOG];
    assign keep_mask = {W{1'b1}} >> amt_i;
    assign masked    = rot & keep_mask;

    always_comb begin
        res_o   = opnd_i;
        carry_o = carry_i;
        unique case (kind)
            SK_SHL, SK_SHL_A: begin
                res_o   = masked_rev;
                carry_o = nonzero ? rot[W-1] : carry_i;
            end
            SK_SHR: begin
                res_o   = masked;
                carry_o = nonzero ? rot[W-1] : carry_i;
            end
            SK_SAR: begin
                res_o   = masked | (opnd_i[W-1] ? ~keep_mask : '0);
                carry_o = nonzero ? rot[W-1] : carry_i;
            end
            SK_ROT: begin
                res_o   = rot;
                carry_o = nonzero ? rot[W-1] : carry_i;
            end
            SK_RCX: begin
                res_o   = {carry_i, opnd_i[W-1:1]};
                carry_o = opnd_i[0];
            end
            SK_RSV6, SK_RSV7: begin
                res_o   = opnd_i;
                carry_o = carry_i;
            end
            default: begin
                res_o   = opnd_i;
                carry_o = carry_i;
            end
        endcase
    end

    always_comb begin
        if (!nonzero && kind_i <= 3'd4) begin
            AST_ZERO_AMT_PASS: assert (res_o == opnd_i && carry_o == carry_i); // R1
        end
        if (kind == SK_RCX) begin
            AST_RCX_MOVE: assert (res_o[W-1] == carry_i && carry_o == opnd_i[0]
                                  && res_o[W-2:0] == opnd_i[W-1:1]); // R6
        end
        if (kind == SK_SAR) begin
            AST_SAR_SIGN: assert (res_o[W-1] == opnd_i[W-1]); // R4
        end
        if (kind == SK_ROT) begin
            AST_ROT_ONES: assert ($countones(res_o) == $countones(opnd_i)); // R5
        end
        if (kind == SK_RSV6 || kind == SK_RSV7) begin
            AST_RSV_PASS: assert (res_o == opnd_i && carry_o == carry_i); // R7
        end
    end

endmodule

// File: rtl/bshift_imm.sv
module bshift_imm #(
    parameter int W     = 32,
    parameter int VAL_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic [ROT_W-1:0] rot_i,
    input  logic             carry_i,
    output logic [W-1:0]     res_o,
    output logic             carry_o
);

    localparam int SH_W = ROT_W + 1;

    logic [W-1:0]   ext;
    logic [2*W-1:0] dbl;
    logic [2*W-1:0] dbl_sh;
    logic [SH_W-1:0] sh;

    assign ext    = W'(val_i);
    assign dbl    = {ext, ext};
    assign sh     = {rot_i, 1'b0};
    assign dbl_sh = dbl >> sh;
    assign res_o  = dbl_sh[W-1:0];
    assign carry_o = (rot_i == '0) ? carry_i : res_o[W-1];

    always_comb begin
        AST_IMM_ONES: assert ($countones(res_o) == $countones(val_i)); // R8
        if (rot_i == '0) begin
            AST_IMM_PLAIN: assert (res_o == ext && carry_o == carry_i); // R9
        end
    end

endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = $clog2(W),
    parameter int VAL_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    input  logic             imm_sel_i,
    input  logic [VAL_W-1:0] imm_val_i,
    input  logic [ROT_W-1:0] imm_rot_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o
);

    logic [W-1:0] reg_res;
    logic         reg_c;
    logic [W-1:0] imm_res;
    logic         imm_c;

    bshift_core #(.W(W), .AMT_W(AMT_W)) u_core (
        .opnd_i  (opnd_i),
        .kind_i  (kind_i),
        .amt_i   (amt_i),
        .carry_i (carry_i),
        .res_o   (reg_res),
        .carry_o (reg_c)
    );

    bshift_imm #(.W(W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_imm (
        .val_i   (imm_val_i),
        .rot_i   (imm_rot_i),
        .carry_i (carry_i),
        .res_o   (imm_res),
        .carry_o (imm_c)
    );

    always_comb begin
        if (imm_sel_i) begin
            result_o = imm_res;
            carry_o  = imm_c;
        end else begin
            result_o = reg_res;
            carry_o  = reg_c;
        end
    end

    always_comb begin
        if (imm_sel_i && imm_rot_i != '0) begin
            AST_IMM_CARRY_TOP: assert (carry_o == result_o[W-1]); // R9
        end
    end

endmodule

// File: tb/tb_bshift_top.sv
module tb_bshift_top;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [2:0]  kind;
    logic [4:0]  amt;
    logic        cin;
    logic        isel;
    logic [7:0]  ival;
    logic [3:0]  irot;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bshift_top dut (
        .opnd_i    (opnd),
        .kind_i    (kind),
        .amt_i     (amt),
        .carry_i   (cin),
        .imm_sel_i (isel),
        .imm_val_i (ival),
        .imm_rot_i (irot),
        .result_o  (res),
        .carry_o   (cout)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic string tag_of(input int k);
        case (k)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            4:       return "R5";
            5:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // behavioural reference for the register path
    task automatic ref_reg(input logic [31:0] a, input int k, input int n, input bit c,
                           output logic [31:0] r, output bit co);
        r = a; co = c;
        if (k == 5) begin
            r = {c, a[31:1]}; co = a[0];
        end else if (k <= 4 && n != 0) begin
            case (k)
                0, 1: begin r = a << n; co = a[32-n]; end
                2:    begin r = a >> n; co = a[n-1]; end
                3:    begin r = 32'($signed(a) >>> n); co = a[n-1]; end
                default: begin r = (a >> n) | (a << (32 - n)); co = a[n-1]; end
            endcase
        end
    endtask

    task automatic ref_imm(input logic [7:0] v, input int n, input bit c,
                           output logic [31:0] r, output bit co);
        logic [31:0] e;
        e = {24'd0, v};
        for (int i = 0; i < 32; i++) r[i] = e[(i + 2*n) % 32];
        co = (n == 0) ? c : r[31];
    endtask

    task automatic compare(input string tag, input logic [31:0] er, input bit ec);
        checks++;
        if (res !== er || cout !== ec) begin
            errors++;
            $display("FAIL %s: kind=%0d amt=%0d sel=%0b val=%h rot=%0d got res=%h c=%0b exp res=%h c=%0b",
                     tag, kind, amt, isel, ival, irot, res, cout, er, ec);
        end
    endtask

    task automatic apply_reg(input logic [31:0] a, input int k, input int n, input bit c);
        logic [31:0] er;
        bit ec;
        @(posedge clk);
        #1;
        isel = 1'b0; opnd = a; kind = 3'(k); amt = 5'(n); cin = c;
        ival = 8'($urandom); irot = 4'($urandom); // R8 other path's inputs must not matter
        ref_reg(a, k, n, c, er, ec);
        @(negedge clk);
        compare((n == 0 && k <= 4) ? "R1" : tag_of(k), er, ec);
    endtask

    task automatic apply_imm(input logic [7:0] v, input int n, input bit c);
        logic [31:0] er;
        bit ec;
        @(posedge clk);
        #1;
        isel = 1'b1; ival = v; irot = 4'(n); cin = c;
        opnd = $urandom; kind = 3'($urandom); amt = 5'($urandom); // R8 ignored inputs
        ref_imm(v, n, c, er, ec);
        @(negedge clk);
        compare((n == 0) ? "R9" : "R8", er, ec);
    endtask

    initial begin
        opnd = '0; kind = '0; amt = '0; cin = 1'b0; isel = 1'b0; ival = '0; irot = '0;
        // initial state: zero inputs pass zero through (R1)
        @(negedge clk);
        compare("R1", 32'h0, 1'b0);

        // fixed corner operands
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 32; n++) begin
                apply_reg(32'h8000_0001, k, n, 1'b1);
                apply_reg(32'h7FFF_FFFE, k, n, 1'b0);
                apply_reg(32'hFFFF_FFFF, k, n, 1'b0);
            end
        end
        // random operands, both carry values, every kind and amount
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 32; n++) begin
                for (int j = 0; j < 4; j++) begin
                    apply_reg($urandom, k, n, j[0]);
                end
            end
        end
        // every constant encoding
        for (int v = 0; v < 256; v++) begin
            for (int n = 0; n < 16; n++) begin
                apply_imm(8'(v), n, bit'($urandom));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule